// File: doc/BRIEF.md
# Event Fanout Processor

This block applies scheduled events to the stored circuit state of a hardware logic simulator. A scheduler offers events one at a time through a level handshake: the block raises its ready line, the scheduler raises an event-valid line with an event on the bus, and the block latches the event and drops ready. The event names a source element, one of its outputs and a new 4-bit value. Once the scheduler has withdrawn the valid line, the block does four things. It writes the value into the output table. It reads the head pointer of that output's fanout list from the topology memory. It walks the linked list node by node, writing the value into the input slot that each node names. For every target element it checks an activation flag. If the flag is clear, the block sets it and appends the element number to the activated-element list.

When the scheduler signals that no events remain, the block waits for that signal to drop. It then raises an evaluate request toward the element evaluator and holds it until the evaluator acknowledges. After that it returns to accepting events for the next simulation cycle. Every memory port has a one-clock registered read, so the block waits one cycle between issuing a read and using its data. The append index into the activated list restarts at zero on each handoff.

Top module: `event_fanout_proc`

## Requirements
- R1: During and right after reset, `sched_rdy` is 1, `eval_req` is 0 and no write enable is active.
- R2: While `sched_rdy` is 1, a 1 on `sched_next` latches the event, and `sched_rdy` is 0 in the following cycle. `sched_rdy` stays 0 until `sched_next` has returned to 0 and the event has been fully applied.
- R3: Each accepted event writes its value into the output table at address `{elem, out_idx}` (element number in the upper bits, output index in the lower `IDX_W` bits).
- R4: The head pointer is read from the topology memory at address `{elem, out_idx}`. Each node supplies a target element, a target input and a next pointer. A pointer of 0 ends the list, and a head of 0 means the output has no fanout.
- R5: For each node visited, the event value is written into the input table at address `{target element, target input}`.
- R6: For each node, a target whose flag reads 0 gets its flag set and its element number appended to the activated list. A target whose flag reads 1 causes no flag or list write. Appends follow the order in which the nodes are visited.
- R7: The first append after each evaluate handoff goes to list index 0, and later appends go to consecutive indices.
- R8: When `sched_none` is 1 while `sched_rdy` is 1, `sched_rdy` drops in the next cycle. `eval_req` rises only after `sched_none` has returned to 0 and then holds until `eval_ack` is 1. In the cycle after the acknowledge, `eval_req` is 0 and `sched_rdy` is 1 again, and `sched_rdy` is never 1 while `eval_req` is 1.
- R9: No table, flag or list write happens while `sched_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_next | input | 1 | Scheduler: an event is valid on the bus |
| sched_none | input | 1 | Scheduler: no events remain this cycle |
| sched_elem | input | ELEM_W | Event source element number |
| sched_out | input | IDX_W | Event output index |
| sched_val | input | VAL_W | Event new value |
| sched_rdy | output | 1 | Ready to take an event or the end marker |
| eval_req | output | 1 | Evaluate request to the evaluator |
| eval_ack | input | 1 | Evaluator acknowledge |
| topo_re | output | 1 | Topology read enable |
| topo_addr | output | ELEM_W+IDX_W | Topology read address |
| topo_rdata | input | PTR_W | Fanout list head pointer (one clock after read) |
| node_re | output | 1 | Fanout node read enable |
| node_addr | output | PTR_W | Fanout node address |
| node_tgt_elem | input | ELEM_W | Node target element |
| node_tgt_in | input | IDX_W | Node target input |
| node_next | input | PTR_W | Node next pointer |
| out_we | output | 1 | Output table write enable |
| out_addr | output | ELEM_W+IDX_W | Output table address |
| out_wdata | output | VAL_W | Output table write data |
| in_we | output | 1 | Input table write enable |
| in_addr | output | ELEM_W+IDX_W | Input table address |
| in_wdata | output | VAL_W | Input table write data |
| flag_re | output | 1 | Flag read enable |
| flag_we | output | 1 | Flag write enable (writes 1) |
| flag_addr | output | ELEM_W | Flag address for read or write |
| flag_rdata | input | 1 | Flag read data (one clock after read) |
| act_we | output | 1 | Activated list write enable |
| act_addr | output | LIST_AW | Activated list write index |
| act_wdata | output | ELEM_W | Activated element number |

## Verification
A stale or misrouted pointer shows up at the port as an input-table write to the wrong slot, or as a walk that ends early or runs too long. It becomes visible in the input table at the next handoff. A flag test that reads the wrong cycle's data shows up as duplicate or missing entries in the activated list, and an append counter that fails to restart shows up as entries that do not begin at index 0. Handshake mistakes appear within one or two clocks on `sched_rdy` and `eval_req`, because both are compared against the scheduler and evaluator levels cycle by cycle.

// File: rtl/efp_pkg.sv
package efp_pkg;

    localparam int unsigned DEF_ELEM_W  = 16;
    localparam int unsigned DEF_VAL_W   = 4;
    localparam int unsigned DEF_IDX_W   = 4;
    localparam int unsigned DEF_PTR_W   = 12;
    localparam int unsigned DEF_LIST_AW = 12;

    typedef enum logic [2:0] {
        RX_LISTEN,
        RX_DRAIN_EVT,
        RX_APPLY,
        RX_DRAIN_END,
        RX_HANDOFF
    } rx_state_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_HEAD,
        WK_NODE,
        WK_FLAG
    } walk_state_e;

    typedef enum logic {
        HO_IDLE,
        HO_REQ
    } handoff_state_e;

endpackage

// File: rtl/efp_sched_rx.sv
module efp_sched_rx
    import efp_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W,
    parameter int unsigned IDX_W  = DEF_IDX_W,
    parameter int unsigned VAL_W  = DEF_VAL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              next_evt,
    input  logic              no_evt,
    input  logic [ELEM_W-1:0] evt_elem,
    input  logic [IDX_W-1:0]  evt_idx,
    input  logic [VAL_W-1:0]  evt_val,
    output logic              ready,
    output logic [ELEM_W-1:0] held_elem,
    output logic [IDX_W-1:0]  held_idx,
    output logic [VAL_W-1:0]  held_val,
    output logic              walk_start,
    input  logic              walk_done,
    output logic              handoff_start,
    input  logic              handoff_done
);

    typedef struct packed {
        logic [ELEM_W-1:0] elem;
        logic [IDX_W-1:0]  idx;
        logic [VAL_W-1:0]  val;
    } evt_t;

    rx_state_e st_q, st_d;
    evt_t      held_q;

    always_comb begin
        st_d          = st_q;
        walk_start    = 1'b0;
        handoff_start = 1'b0;
        case (st_q)
            RX_LISTEN: begin
                if (next_evt)    st_d = RX_DRAIN_EVT;
                else if (no_evt) st_d = RX_DRAIN_END;
            end
            RX_DRAIN_EVT: begin
                if (!next_evt) begin
                    walk_start = 1'b1;
                    st_d       = RX_APPLY;
                end
            end
            RX_APPLY: begin
                if (walk_done) st_d = RX_LISTEN;
            end
            RX_DRAIN_END: begin
                if (!no_evt) begin
                    handoff_start = 1'b1;
                    st_d          = RX_HANDOFF;
                end
            end
            RX_HANDOFF: begin
                if (handoff_done) st_d = RX_LISTEN;
            end
            default: st_d = RX_LISTEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_LISTEN;
            held_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == RX_LISTEN && next_evt)
                held_q <= '{elem: evt_elem, idx: evt_idx, val: evt_val};
        end
    end

    assign ready     = (st_q == RX_LISTEN);
    assign held_elem = held_q.elem;
    assign held_idx  = held_q.idx;
    assign held_val  = held_q.val;

    // R2: an offered event takes ready away in the next cycle
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (ready && next_evt) |=> !ready);

    // R8: the end marker also takes ready away in the next cycle
    a_r8_end_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (ready && no_evt && !next_evt) |=> !ready);

    // R2: the walk only starts after the scheduler has released its valid line
    a_r2_walk_after_release: assert property (@(posedge clk) disable iff (rst)
        walk_start |-> !next_evt);

endmodule

// File: rtl/efp_fanout_walk.sv
module efp_fanout_walk
    import efp_pkg::*;
#(
    parameter int unsigned ELEM_W  = DEF_ELEM_W,
    parameter int unsigned IDX_W   = DEF_IDX_W,
    parameter int unsigned VAL_W   = DEF_VAL_W,
    parameter int unsigned PTR_W   = DEF_PTR_W,
    parameter int unsigned LIST_AW = DEF_LIST_AW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ELEM_W-1:0]       ev_elem,
    input  logic [IDX_W-1:0]        ev_idx,
    input  logic [VAL_W-1:0]        ev_val,
    output logic                    done,
    input  logic                    cnt_clr,
    output logic                    topo_re,
    output logic [ELEM_W+IDX_W-1:0] topo_addr,
    input  logic [PTR_W-1:0]        topo_rdata,
    output logic                    node_re,
    output logic [PTR_W-1:0]        node_addr,
    input  logic [ELEM_W-1:0]       node_tgt_elem,
    input  logic [IDX_W-1:0]        node_tgt_in,
    input  logic [PTR_W-1:0]        node_next,
    output logic                    out_we,
    output logic [ELEM_W+IDX_W-1:0] out_addr,
    output logic [VAL_W-1:0]        out_wdata,
    output logic                    in_we,
    output logic [ELEM_W+IDX_W-1:0] in_addr,
    output logic [VAL_W-1:0]        in_wdata,
    output logic                    flag_re,
    output logic                    flag_we,
    output logic [ELEM_W-1:0]       flag_addr,
    input  logic                    flag_rdata,
    output logic                    act_we,
    output logic [LIST_AW-1:0]      act_addr,
    output logic [ELEM_W-1:0]       act_wdata
);

    localparam logic [PTR_W-1:0] NULL_PTR = '0;

    typedef struct packed {
        logic [ELEM_W-1:0] elem;
        logic [IDX_W-1:0]  pin;
        logic [PTR_W-1:0]  next;
    } node_t;

    walk_state_e        st_q, st_d;
    node_t              node_q;
    logic [LIST_AW-1:0] cnt_q;

    always_comb begin
        st_d      = st_q;
        done      = 1'b0;
        topo_re   = 1'b0;
        node_re   = 1'b0;
        out_we    = 1'b0;
        in_we     = 1'b0;
        flag_re   = 1'b0;
        flag_we   = 1'b0;
        act_we    = 1'b0;
        topo_addr = {ev_elem, ev_idx};
        out_addr  = {ev_elem, ev_idx};
        out_wdata = ev_val;
        in_addr   = {node_tgt_elem, node_tgt_in};
        in_wdata  = ev_val;
        node_addr = (st_q == WK_HEAD) ? topo_rdata : node_q.next;
        flag_addr = (st_q == WK_NODE) ? node_tgt_elem : node_q.elem;
        act_addr  = cnt_q;
        act_wdata = node_q.elem;
        case (st_q)
            WK_IDLE: begin
                if (start) begin
                    out_we  = 1'b1;
                    topo_re = 1'b1;
                    st_d    = WK_HEAD;
                end
            end
            WK_HEAD: begin
                if (topo_rdata == NULL_PTR) begin
                    done = 1'b1;
                    st_d = WK_IDLE;
                end else begin
                    node_re = 1'b1;
                    st_d    = WK_NODE;
                end
            end
            WK_NODE: begin
                in_we   = 1'b1;
                flag_re = 1'b1;
                st_d    = WK_FLAG;
            end
            WK_FLAG: begin
                if (!flag_rdata) begin
                    flag_we = 1'b1;
                    act_we  = 1'b1;
                end
                if (node_q.next == NULL_PTR) begin
                    done = 1'b1;
                    st_d = WK_IDLE;
                end else begin
                    node_re = 1'b1;
                    st_d    = WK_NODE;
                end
            end
            default: st_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WK_IDLE;
            node_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == WK_NODE)
                node_q <= '{elem: node_tgt_elem, pin: node_tgt_in, next: node_next};
            if (cnt_clr)
                cnt_q <= '0;
            else if (act_we)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: every input write uses node data fetched by the previous cycle's read
    a_r4_node_read_first: assert property (@(posedge clk) disable iff (rst)
        in_we |-> $past(node_re));

    // R6: a flag test always follows the input write of the same node
    a_r6_flag_after_input: assert property (@(posedge clk) disable iff (rst)
        flag_re |=> !in_we);

    // R7: after a handoff the append index is back at zero
    a_r7_index_restart: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (act_addr == '0));

    // R3: the output write only happens in the cycle that starts a walk
    a_r3_out_on_start: assert property (@(posedge clk) disable iff (rst)
        out_we |=> topo_re == 1'b0);

endmodule

// File: rtl/efp_eval_handoff.sv
module efp_eval_handoff
    import efp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic evaluate,
    output logic done
);

    handoff_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= HO_IDLE;
        end else begin
            case (st_q)
                HO_IDLE: if (start) st_q <= HO_REQ;
                HO_REQ:  if (ack)   st_q <= HO_IDLE;
                default:            st_q <= HO_IDLE;
            endcase
        end
    end

    assign evaluate = (st_q == HO_REQ);
    assign done     = evaluate && ack;

    // R8: the request is held until the evaluator acknowledges
    a_r8_req_holds: assert property (@(posedge clk) disable iff (rst)
        (evaluate && !ack) |=> evaluate);

    // R8: the request drops right after the acknowledge
    a_r8_req_drops: assert property (@(posedge clk) disable iff (rst)
        (evaluate && ack) |=> !evaluate);

endmodule

// File: rtl/event_fanout_proc.sv
module event_fanout_proc
    import efp_pkg::*;
#(
    parameter int unsigned ELEM_W  = DEF_ELEM_W,
    parameter int unsigned IDX_W   = DEF_IDX_W,
    parameter int unsigned VAL_W   = DEF_VAL_W,
    parameter int unsigned PTR_W   = DEF_PTR_W,
    parameter int unsigned LIST_AW = DEF_LIST_AW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sched_next,
    input  logic                    sched_none,
    input  logic [ELEM_W-1:0]       sched_elem,
    input  logic [IDX_W-1:0]        sched_out,
    input  logic [VAL_W-1:0]        sched_val,
    output logic                    sched_rdy,
    output logic                    eval_req,
    input  logic                    eval_ack,
    output logic                    topo_re,
    output logic [ELEM_W+IDX_W-1:0] topo_addr,
    input  logic [PTR_W-1:0]        topo_rdata,
    output logic                    node_re,
    output logic [PTR_W-1:0]        node_addr,
    input  logic [ELEM_W-1:0]       node_tgt_elem,
    input  logic [IDX_W-1:0]        node_tgt_in,
    input  logic [PTR_W-1:0]        node_next,
    output logic                    out_we,
    output logic [ELEM_W+IDX_W-1:0] out_addr,
    output logic [VAL_W-1:0]        out_wdata,
    output logic                    in_we,
    output logic [ELEM_W+IDX_W-1:0] in_addr,
    output logic [VAL_W-1:0]        in_wdata,
    output logic                    flag_re,
    output logic                    flag_we,
    output logic [ELEM_W-1:0]       flag_addr,
    input  logic                    flag_rdata,
    output logic                    act_we,
    output logic [LIST_AW-1:0]      act_addr,
    output logic [ELEM_W-1:0]       act_wdata
);

    logic [ELEM_W-1:0] held_elem;
    logic [IDX_W-1:0]  held_idx;
    logic [VAL_W-1:0]  held_val;
    logic              walk_start, walk_done;
    logic              ho_start, ho_done;

    efp_sched_rx #(
        .ELEM_W(ELEM_W), .IDX_W(IDX_W), .VAL_W(VAL_W)
    ) u_rx (
        .clk          (clk),
        .rst          (rst),
        .next_evt     (sched_next),
        .no_evt       (sched_none),
        .evt_elem     (sched_elem),
        .evt_idx      (sched_out),
        .evt_val      (sched_val),
        .ready        (sched_rdy),
        .held_elem    (held_elem),
        .held_idx     (held_idx),
        .held_val     (held_val),
        .walk_start   (walk_start),
        .walk_done    (walk_done),
        .handoff_start(ho_start),
        .handoff_done (ho_done)
    );

    efp_fanout_walk #(
        .ELEM_W(ELEM_W), .IDX_W(IDX_W), .VAL_W(VAL_W),
        .PTR_W(PTR_W), .LIST_AW(LIST_AW)
    ) u_walk (
        .clk          (clk),
        .rst          (rst),
        .start        (walk_start),
        .ev_elem      (held_elem),
        .ev_idx       (held_idx),
        .ev_val       (held_val),
        .done         (walk_done),
        .cnt_clr      (ho_done),
        .topo_re      (topo_re),
        .topo_addr    (topo_addr),
        .topo_rdata   (topo_rdata),
        .node_re      (node_re),
        .node_addr    (node_addr),
        .node_tgt_elem(node_tgt_elem),
        .node_tgt_in  (node_tgt_in),
        .node_next    (node_next),
        .out_we       (out_we),
        .out_addr     (out_addr),
        .out_wdata    (out_wdata),
        .in_we        (in_we),
        .in_addr      (in_addr),
        .in_wdata     (in_wdata),
        .flag_re      (flag_re),
        .flag_we      (flag_we),
        .flag_addr    (flag_addr),
        .flag_rdata   (flag_rdata),
        .act_we       (act_we),
        .act_addr     (act_addr),
        .act_wdata    (act_wdata)
    );

    efp_eval_handoff u_ho (
        .clk     (clk),
        .rst     (rst),
        .start   (ho_start),
        .ack     (eval_ack),
        .evaluate(eval_req),
        .done    (ho_done)
    );

    // R8: the scheduler side and the evaluator side never overlap
    a_r8_ready_vs_eval: assert property (@(posedge clk) disable iff (rst)
        eval_req |-> !sched_rdy);

    // R9: no state write while waiting for the scheduler
    a_r9_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
        sched_rdy |-> !(out_we || in_we || flag_we || act_we));

    // R6: each append goes with a flag set for the same element
    a_r6_append_sets_flag: assert property (@(posedge clk) disable iff (rst)
        act_we |-> (flag_we && flag_addr == act_wdata));

    // R1: no write enable during reset
    always_ff @(posedge clk) begin
        if (rst) begin
            a_r1_reset_quiet: assert (!out_we && !in_we && !flag_we && !act_we);
        end
    end

endmodule

// File: tb/event_fanout_proc_test.sv
module event_fanout_proc_test;

    localparam int EW = 5;
    localparam int IW = 2;
    localparam int VW = 4;
    localparam int PW = 5;
    localparam int LW = 5;
    localparam int NE = 1 << EW;
    localparam int NT = 1 << (EW + IW);
    localparam int NN = 1 << PW;
    localparam int NL = 1 << LW;
    localparam int NO = 1 << IW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          sched_next = 0, sched_none = 0, eval_ack = 0;
    logic [EW-1:0] sched_elem = '0;
    logic [IW-1:0] sched_out = '0;
    logic [VW-1:0] sched_val = '0;
    logic sched_rdy, eval_req, topo_re, node_re, out_we, in_we, flag_re, flag_we, act_we;
    logic [EW+IW-1:0] topo_addr, out_addr, in_addr;
    logic [PW-1:0] node_addr;
    logic [VW-1:0] out_wdata, in_wdata;
    logic [EW-1:0] flag_addr, act_wdata;
    logic [LW-1:0] act_addr;

    logic [PW-1:0] topo_q = '0, nq_next = '0;
    logic [EW-1:0] nq_elem = '0;
    logic [IW-1:0] nq_in = '0;
    logic          flag_q = 1'b0;

    logic [PW-1:0] topo_mem [NT];
    logic [EW-1:0] nd_elem  [NN];
    logic [IW-1:0] nd_in    [NN];
    logic [PW-1:0] nd_next  [NN];
    logic [VW-1:0] out_mem  [NT];
    logic [VW-1:0] in_mem   [NT];
    logic          flag_mem [NE];
    logic [EW-1:0] ael_mem  [NL];

    logic [VW-1:0] m_out  [NT];
    logic [VW-1:0] m_in   [NT];
    logic          m_flag [NE];
    logic [EW-1:0] m_ael  [NL];
    int            m_cnt;

    int total = 0;
    int bad = 0;

    event_fanout_proc #(
        .ELEM_W(EW), .IDX_W(IW), .VAL_W(VW), .PTR_W(PW), .LIST_AW(LW)
    ) uut (
        .clk(clk), .rst(rst),
        .sched_next(sched_next), .sched_none(sched_none),
        .sched_elem(sched_elem), .sched_out(sched_out), .sched_val(sched_val),
        .sched_rdy(sched_rdy), .eval_req(eval_req), .eval_ack(eval_ack),
        .topo_re(topo_re), .topo_addr(topo_addr), .topo_rdata(topo_q),
        .node_re(node_re), .node_addr(node_addr),
        .node_tgt_elem(nq_elem), .node_tgt_in(nq_in), .node_next(nq_next),
        .out_we(out_we), .out_addr(out_addr), .out_wdata(out_wdata),
        .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
        .flag_re(flag_re), .flag_we(flag_we), .flag_addr(flag_addr), .flag_rdata(flag_q),
        .act_we(act_we), .act_addr(act_addr), .act_wdata(act_wdata)
    );

    // memories with one-clock registered reads
    always @(posedge clk) begin
        if (topo_re) topo_q <= topo_mem[topo_addr];
        if (node_re) begin
            nq_elem <= nd_elem[node_addr];
            nq_in   <= nd_in[node_addr];
            nq_next <= nd_next[node_addr];
        end
        if (flag_re) flag_q <= flag_mem[flag_addr];
        if (out_we)  out_mem[out_addr] <= out_wdata;
        if (in_we)   in_mem[in_addr] <= in_wdata;
        if (flag_we) flag_mem[flag_addr] <= 1'b1;
        if (act_we)  ael_mem[act_addr] <= act_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_apply(input int e, input int o, input int v);
        int p;
        int te;
        m_out[e*NO+o] = v[VW-1:0];
        p = int'(topo_mem[e*NO+o]);
        while (p != 0) begin
            te = int'(nd_elem[p]);
            m_in[te*NO + int'(nd_in[p])] = v[VW-1:0];
            if (!m_flag[te]) begin
                m_flag[te] = 1'b1;
                m_ael[m_cnt] = te[EW-1:0];
                m_cnt++;
            end
            p = int'(nd_next[p]);
        end
    endtask

    task automatic send_event(input int e, input int o, input int v);
        while (sched_rdy !== 1'b1) @(negedge clk);
        sched_elem = e[EW-1:0];
        sched_out  = o[IW-1:0];
        sched_val  = v[VW-1:0];
        sched_next = 1'b1;
        @(negedge clk);
        chk(sched_rdy == 1'b0, "R2 ready low after event", int'(sched_rdy), 0);
        @(negedge clk);
        chk(sched_rdy == 1'b0, "R2 ready held while valid high", int'(sched_rdy), 0);
        sched_next = 1'b0;
        model_apply(e, o, v);
        while (sched_rdy !== 1'b1) @(negedge clk);
    endtask

    task automatic compare_state(input int cyc);
        int d;
        d = 0;
        for (int i = 0; i < NT; i++) if (out_mem[i] !== m_out[i]) d++;
        chk(d == 0, $sformatf("R3 output table cycle %0d mismatches", cyc), d, 0);
        d = 0;
        for (int i = 0; i < NT; i++) if (in_mem[i] !== m_in[i]) d++;
        chk(d == 0, $sformatf("R5 input table via R4 walk cycle %0d mismatches", cyc), d, 0);
        d = 0;
        for (int i = 0; i < NE; i++) if (flag_mem[i] !== m_flag[i]) d++;
        chk(d == 0, $sformatf("R6 flags cycle %0d mismatches", cyc), d, 0);
        d = 0;
        for (int i = 0; i < NL; i++) if (ael_mem[i] !== m_ael[i]) d++;
        chk(d == 0, $sformatf("R7 list from index 0 cycle %0d mismatches", cyc), d, 0);
    endtask

    task automatic end_cycle(input int cyc);
        while (sched_rdy !== 1'b1) @(negedge clk);
        sched_none = 1'b1;
        @(negedge clk);
        chk(sched_rdy == 1'b0, "R8 ready low after end marker", int'(sched_rdy), 0);
        repeat (3) @(negedge clk);
        chk(eval_req == 1'b0, "R8 no request while end marker high", int'(eval_req), 0);
        sched_none = 1'b0;
        @(negedge clk);
        chk(eval_req == 1'b1, "R8 request after end marker drops", int'(eval_req), 1);
        chk(sched_rdy == 1'b0, "R8 ready low during request", int'(sched_rdy), 0);
        compare_state(cyc);
        for (int i = 0; i < NE; i++) begin flag_mem[i] = 1'b0; m_flag[i] = 1'b0; end
        for (int i = 0; i < NL; i++) begin ael_mem[i] = '0; m_ael[i] = '0; end
        m_cnt = 0;
        repeat (2) @(negedge clk);
        chk(eval_req == 1'b1, "R8 request held until ack", int'(eval_req), 1);
        eval_ack = 1'b1;
        @(negedge clk);
        chk(eval_req == 1'b0, "R8 request low after ack", int'(eval_req), 0);
        chk(sched_rdy == 1'b1, "R8 ready back after ack", int'(sched_rdy), 1);
        eval_ack = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < NN; k++) begin
            nd_elem[k] = (k == 0) ? '0 : EW'((k * 5) % 31 + 1);
            nd_in[k]   = IW'(k % NO);
            nd_next[k] = (k == 0 || k % 4 == 0 || k == NN - 1) ? '0 : PW'(k + 1);
        end
        for (int s = 0; s < NE; s++)
            for (int o = 0; o < NO; o++)
                topo_mem[s*NO+o] = ((s + o) % 3 == 0) ? '0 : PW'(((s * 3 + o) % 8) * 4 + 1);
        for (int i = 0; i < NT; i++) begin
            out_mem[i] = '0; in_mem[i] = '0; m_out[i] = '0; m_in[i] = '0;
        end
        for (int i = 0; i < NE; i++) begin flag_mem[i] = 1'b0; m_flag[i] = 1'b0; end
        for (int i = 0; i < NL; i++) begin ael_mem[i] = '0; m_ael[i] = '0; end
        m_cnt = 0;

        repeat (3) @(negedge clk);
        chk(sched_rdy == 1'b1, "R1 ready during reset", int'(sched_rdy), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(sched_rdy == 1'b1, "R1 ready after reset", int'(sched_rdy), 1);
        chk(eval_req == 1'b0, "R1 no request after reset", int'(eval_req), 0);
        chk(!(out_we || in_we || flag_we || act_we), "R1 R9 no writes after reset",
            int'({out_we, in_we, flag_we, act_we}), 0);

        // two quiet cycles with the scheduler idle: nothing may be written
        repeat (2) @(negedge clk);
        chk(out_mem[0] == '0 && in_mem[0] == '0, "R9 tables untouched while idle",
            int'(out_mem[0]) + int'(in_mem[0]), 0);

        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < c; i++) begin
                int e, o, v;
                e = (c * 7 + i * 3) % NE;
                o = (c + i) % NO;
                v = (c * 5 + i + 1) % 16;
                if (i == 2) begin
                    // repeat an earlier source of this cycle to hit set flags
                    e = (c * 7) % NE;
                    o = c % NO;
                end
                send_event(e, o, v);
            end
            end_cycle(c);
        end

        // a source with an empty list (R4 null head) then a full list, same target twice
        send_event(0, 0, 9);
        send_event(1, 0, 6);
        send_event(1, 0, 11);
        end_cycle(99);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule